// File: doc/BRIEF.md
# Adaptive Error-Count-Steered Correction Stage

This block is the last stage of a fully parallel decoder for a short binary BCH code that corrects two errors and detects three, the kind used to protect embedded non-volatile memory. An upstream classifier supplies four things: the first and third syndromes, a 2-bit error-count flag, and the received word. From these the block picks the cheapest repair for each word. A word with no error, or with three errors, goes around both correctors. A single error is located by matching the first syndrome against each column of the parity-check matrix. A double error is located by a root test of the error-locator quadratic, applied at every bit position in parallel.

Two register banks stand between the syndrome inputs and the correctors. Each bank captures its syndromes on the falling edge of the decoder clock, and only when the flag selects that corrector. The correctors therefore see only settled values, and at most one of them changes its inputs on any edge. A rising-edge output register then presents the repaired word together with the flag, so an uncorrectable word is reported upstream next to its unmodified data.

Top module: `adaptive_corr_ctrl`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it is sampled, `fix_word` is all zero and `fix_flag` is 00.
- R2: Inputs held across a falling edge of `clk` appear at the outputs after the next rising edge. With flag 00 (no error), `fix_word` equals `rx_word`.
- R3: With flag 01 (single error) and `syn1` equal to alpha^i, only bit i of `rx_word` is inverted. Bit i of the word maps to alpha^i in GF(2^6), built on x^6+x+1, for i from 0 to 62.
- R4: With flag 01 and `syn1` equal to zero, the error is taken to be in the overall parity bit, and `fix_word` equals `rx_word`.
- R5: With flag 10 (double error), `syn1` = alpha^a + alpha^b and `syn3` = alpha^3a + alpha^3b, with a different from b, exactly bits a and b are inverted.
- R6: With flag 11 (uncorrectable), `fix_word` equals `rx_word` and `fix_flag` is 11.
- R7: `fix_flag` equals the flag that was captured together with the word shown on `fix_word`.
- R8: The single-error bank changes only on a falling edge where the flag is 01. The double-error bank changes only on a falling edge where the flag is 10. Neither bank changes for flags 00 and 11, and the two banks never load on the same edge.
- R9: A new word can be applied every cycle. Each output word is repaired using only its own flag and syndromes, whatever the flag of the word before it.
- R10: With flag 10 and `syn1` equal to zero, no bit is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock. Banks capture on the falling edge; output updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ecnt_flag | input | 2 | Error count class: 00 none, 01 single, 10 double, 11 uncorrectable |
| syn1 | input | 6 | First syndrome, an element of GF(2^6) |
| syn3 | input | 6 | Third syndrome, an element of GF(2^6) |
| rx_word | input | 63 | Received word; bit i sits at locator alpha^i |
| fix_word | output | 63 | Repaired word |
| fix_flag | output | 2 | Flag belonging to the word on `fix_word` |

## Verification
Within one clock period the block can load one bank for a new word and also present, on the output, the repair of the previous word from the other bank. Both happen when words with different flags arrive back to back. The stimulus table is walked with no gap between entries, so single, double, bypass and parity-only words follow one another directly. Every output word is compared against the expected data for its own entry. A bank that loads at the wrong time, or a select that follows the wrong flag, shows up as a corrupted neighbour word.

// File: rtl/ecc_gf_pkg.sv
`timescale 1ns/1ps
package ecc_gf_pkg;
  localparam int GF_M = 6;
  localparam logic [GF_M:0] GF_POLY = 7'b1000011;
  localparam int GF_N = (1 << GF_M) - 1;

  typedef logic [GF_M-1:0] gf_t;

  typedef enum logic [1:0] {
    ECNT_NONE = 2'b00,
    ECNT_ONE  = 2'b01,
    ECNT_TWO  = 2'b10,
    ECNT_MANY = 2'b11
  } ecnt_e;

  function automatic gf_t gf_xtime(gf_t a);
    gf_t r;
    r = {a[GF_M-2:0], 1'b0};
    if (a[GF_M-1]) r = r ^ GF_POLY[GF_M-1:0];
    return r;
  endfunction

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    acc = '0;
    for (int k = GF_M - 1; k >= 0; k--) begin
      acc = gf_xtime(acc);
      if (b[k]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic gf_t gf_alpha(int e);
    gf_t r;
    r = gf_t'(1);
    for (int k = 0; k < e; k++) r = gf_xtime(r);
    return r;
  endfunction
endpackage

// File: rtl/cc_syn_bank.sv
`timescale 1ns/1ps
module cc_syn_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Falling-edge capture: the clock-enable replaces the gated register clock.
  always_ff @(negedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/cc_se_locator.sv
`timescale 1ns/1ps
module cc_se_locator
  import ecc_gf_pkg::*;
#(
  parameter int NBITS = GF_N
) (
  input  gf_t              s1,
  output logic [NBITS-1:0] err
);
  // One column comparator per position; zero never matches a column.
  for (genvar i = 0; i < NBITS; i++) begin : g_col
    localparam gf_t COL = gf_alpha(i);
    assign err[i] = (s1 == COL);
  end
endmodule

// File: rtl/cc_de_locator.sv
`timescale 1ns/1ps
module cc_de_locator
  import ecc_gf_pkg::*;
#(
  parameter int NBITS = GF_N
) (
  input  gf_t              s1,
  input  gf_t              s3,
  output logic [NBITS-1:0] err
);
  gf_t  s1_sq;
  gf_t  k_term;
  logic s1_nz;

  // Locator scaled by s1: s1*x^2 + s1^2*x + (s1^3 + s3) = 0 at x = alpha^i.
  assign s1_sq  = gf_mul(s1, s1);
  assign k_term = gf_mul(s1_sq, s1) ^ s3;
  assign s1_nz  = |s1;

  for (genvar i = 0; i < NBITS; i++) begin : g_root
    localparam gf_t X1 = gf_alpha(i);
    localparam gf_t X2 = gf_alpha((2 * i) % GF_N);
    gf_t val;
    assign val    = gf_mul(s1, X2) ^ gf_mul(s1_sq, X1) ^ k_term;
    assign err[i] = s1_nz && (val == '0);
  end
endmodule

// File: rtl/adaptive_corr_ctrl.sv
`timescale 1ns/1ps
module adaptive_corr_ctrl
  import ecc_gf_pkg::*;
#(
  parameter int NBITS = GF_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       ecnt_flag,
  input  logic [GF_M-1:0]  syn1,
  input  logic [GF_M-1:0]  syn3,
  input  logic [NBITS-1:0] rx_word,
  output logic [NBITS-1:0] fix_word,
  output logic [1:0]       fix_flag
);
  localparam int DEW = 2 * GF_M;

  ecnt_e            flag_q;
  logic [NBITS-1:0] rx_q;
  logic             se_ld;
  logic             de_ld;
  gf_t              se_s1_q;
  logic [DEW-1:0]   de_q;
  logic [NBITS-1:0] se_err;
  logic [NBITS-1:0] de_err;
  logic [NBITS-1:0] err_sel;

  assign se_ld = (ecnt_e'(ecnt_flag) == ECNT_ONE);
  assign de_ld = (ecnt_e'(ecnt_flag) == ECNT_TWO);

  // Word and flag travel alongside the banks on the same falling edge.
  always_ff @(negedge clk) begin
    if (rst) begin
      flag_q <= ECNT_NONE;
      rx_q   <= '0;
    end else begin
      flag_q <= ecnt_e'(ecnt_flag);
      rx_q   <= rx_word;
    end
  end

  cc_syn_bank #(.W(GF_M)) u_se_bank (
    .clk (clk), .rst (rst), .ld (se_ld), .d (syn1), .q (se_s1_q)
  );

  cc_syn_bank #(.W(DEW)) u_de_bank (
    .clk (clk), .rst (rst), .ld (de_ld), .d ({syn3, syn1}), .q (de_q)
  );

  cc_se_locator #(.NBITS(NBITS)) u_se_loc (
    .s1 (se_s1_q), .err (se_err)
  );

  cc_de_locator #(.NBITS(NBITS)) u_de_loc (
    .s1 (de_q[GF_M-1:0]), .s3 (de_q[DEW-1:GF_M]), .err (de_err)
  );

  // Three-way choice of error vector: zero, single or double.
  always_comb begin
    unique case (flag_q)
      ECNT_ONE: err_sel = se_err;
      ECNT_TWO: err_sel = de_err;
      default:  err_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_word <= '0;
      fix_flag <= 2'b00;
    end else begin
      fix_word <= rx_q ^ err_sel;
      fix_flag <= flag_q;
    end
  end

  AST_SE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_q != ECNT_ONE) |-> $stable(se_s1_q)); // R8
  AST_DE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (flag_q != ECNT_TWO) |-> $stable(de_q)); // R8
  AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (fix_flag == 2'b00 || fix_flag == 2'b11) |-> (fix_word == $past(rx_q))); // R2
  AST_SE_ONEBIT: assert property (@(posedge clk) disable iff (rst)
    (fix_flag == 2'b01) |-> ($countones(fix_word ^ $past(rx_q)) <= 1)); // R3
  AST_DE_TWOBIT: assert property (@(posedge clk) disable iff (rst)
    (fix_flag == 2'b10) |-> ($countones(fix_word ^ $past(rx_q)) <= 2)); // R5
endmodule

// File: tb/sim_adaptive_corr_ctrl.sv
`timescale 1ns/1ps
module sim_adaptive_corr_ctrl;
  localparam int N = 63;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   ecnt_flag;
  logic [5:0]   syn1;
  logic [5:0]   syn3;
  logic [N-1:0] rx_word;
  logic [N-1:0] fix_word;
  logic [1:0]   fix_flag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  adaptive_corr_ctrl u0 (
    .clk (clk), .rst (rst), .ecnt_flag (ecnt_flag), .syn1 (syn1),
    .syn3 (syn3), .rx_word (rx_word), .fix_word (fix_word), .fix_flag (fix_flag)
  );

  // Entry: flag[37:36] count[35:34] a[33:28] b[27:22] c[21:16] seed[15:0]
  localparam logic [37:0] VEC [0:NV-1] = '{
    {2'd0, 2'd0, 6'd0,  6'd0,  6'd0,  16'hA5C3},  // R2 clean
    {2'd1, 2'd1, 6'd0,  6'd0,  6'd0,  16'h1234},  // R3 bit 0
    {2'd1, 2'd1, 6'd62, 6'd0,  6'd0,  16'hFFFF},  // R3 top bit
    {2'd2, 2'd2, 6'd3,  6'd40, 6'd0,  16'h0F0F},  // R5 after single, R9
    {2'd1, 2'd1, 6'd17, 6'd0,  6'd0,  16'h5A5A},  // R3 after double, R9
    {2'd2, 2'd2, 6'd0,  6'd62, 6'd0,  16'h0000},  // R5 both ends
    {2'd3, 2'd3, 6'd5,  6'd9,  6'd30, 16'hC3C3},  // R6 uncorrectable
    {2'd2, 2'd2, 6'd1,  6'd2,  6'd0,  16'h8001},  // R5 adjacent, R8
    {2'd1, 2'd0, 6'd0,  6'd0,  6'd0,  16'h7777},  // R4 parity-only
    {2'd0, 2'd0, 6'd0,  6'd0,  6'd0,  16'h3C3C},  // R2 clean
    {2'd2, 2'd2, 6'd10, 6'd11, 6'd0,  16'h6969},  // R5
    {2'd1, 2'd1, 6'd44, 6'd0,  6'd0,  16'hBEEF}   // R3
  };

  function automatic logic [5:0] ta(int e);
    logic [5:0] r;
    r = 6'd1;
    repeat (e % 63) r = {r[4:0], 1'b0} ^ (r[5] ? 6'b000011 : 6'b000000);
    return r;
  endfunction

  task automatic build(input logic [37:0] v, output logic [N-1:0] rxw,
                       output logic [5:0] s1v, output logic [5:0] s3v,
                       output logic [N-1:0] expw);
    logic [63:0]  d64;
    logic [N-1:0] data;
    logic [N-1:0] e;
    int cnt;
    int pos [3];
    d64 = {4{v[15:0]}};
    data = d64[N-1:0];
    cnt = int'(v[35:34]);
    pos[0] = int'(v[33:28]);
    pos[1] = int'(v[27:22]);
    pos[2] = int'(v[21:16]);
    e = '0; s1v = '0; s3v = '0;
    for (int k = 0; k < cnt; k++) begin
      e[pos[k]] = 1'b1;
      s1v = s1v ^ ta(pos[k]);
      s3v = s3v ^ ta(3 * pos[k]);
    end
    rxw = data ^ e;
    expw = (v[37:36] == 2'd3) ? rxw : data;
  endtask

  task automatic chk(input string req, input logic [N-1:0] ew, input logic [1:0] ef);
    checks++;
    if (fix_word !== ew || fix_flag !== ef) begin
      errors++;
      $display("FAIL %s: word=%h flag=%b expected word=%h flag=%b",
               req, fix_word, fix_flag, ew, ef);
    end
  endtask

  initial begin
    logic [N-1:0] rxw, expw;
    logic [N-1:0] pexp;
    logic [1:0]   pflag;
    logic [5:0]   s1v, s3v;
    rst = 1'b1; ecnt_flag = 2'b00; syn1 = '0; syn3 = '0; rx_word = {N{1'b1}};
    repeat (4) @(posedge clk);
    #1 chk("R1", '0, 2'b00);
    rst = 1'b0;
    pexp = '0; pflag = 2'b00;
    // Back-to-back walk: each cycle checks the previous entry and applies the next.
    for (int k = 0; k < NV; k++) begin
      build(VEC[k], rxw, s1v, s3v, expw);
      ecnt_flag = VEC[k][37:36]; syn1 = s1v; syn3 = s3v; rx_word = rxw;
      @(posedge clk); #1;
      chk($sformatf("R9/R7 entry %0d", k), expw, VEC[k][37:36]);
    end
    // R10: double flag with zero first syndrome changes nothing.
    ecnt_flag = 2'b10; syn1 = 6'd0; syn3 = 6'd5; rx_word = 63'h1234_5678_9ABC_DEF0;
    @(posedge clk); #1 chk("R10", 63'h1234_5678_9ABC_DEF0, 2'b10);
    // R8: flags 00 and 11 must leave the single bank intact for a later single word.
    build(VEC[4], rxw, s1v, s3v, expw);
    ecnt_flag = 2'b01; syn1 = s1v; syn3 = s3v; rx_word = rxw;
    @(posedge clk); #1 chk("R3 load", expw, 2'b01);
    ecnt_flag = 2'b11; syn1 = 6'd33; syn3 = 6'd7; rx_word = 63'h7;
    @(posedge clk); #1 chk("R6 flag reported", 63'h7, 2'b11);
    ecnt_flag = 2'b00; syn1 = 6'd21; rx_word = '0;
    @(posedge clk); #1 chk("R8 none flag ignored syndromes", '0, 2'b00);
    // R7/R2: held inputs give the same output again.
    @(posedge clk); #1 chk("R2 held", '0, 2'b00);
    // R1: reset mid-run clears outputs.
    ecnt_flag = 2'b01; syn1 = ta(7); rx_word = '1;
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1 chk("R1 mid-run", '0, 2'b00);
    rst = 1'b0;
    @(posedge clk); #1 chk("R3 after reset", ~(63'd1 << 7), 2'b01);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule